// File: doc/BRIEF.md
# Dual-Bitmap Outbound Slot Scheduler

This block decides, one slot at a time, which channel an outbound link carries next. It walks a programmed group of positions in round-robin order and maps each position through a per-link lookup table to a channel number between 0 and 127. Two bitmap words, each with a programmed length, decide at the end of which group cycles a run of empty "bubble" slots follows; the run length is programmable. Spreading the bubbles this way lets a channel mix whose sample rate is not an integer multiple of the slot rate fill a fixed frame exactly.

Each slot the block raises a valid flag with the channel number, or drops the flag for a bubble while the channel output keeps its last value. A frame boundary strobe restarts the schedule. A parameter selects how slot strobes are counted: a link that carries fixed message slots takes one schedule step per strobe, while a link that places samples by position counts byte strobes and takes a step per four-byte sample.

Top module: `bmap_slot_sched`

## Requirements
- R1: After reset `slot_vld` is 0 and `slot_ch` is 0.
- R2: With no bubble due, successive slots are valid and carry the table entries for positions 0, 1, ..., `grp_size`-1, then position 0 again, in that order.
- R3: Bubbles start only after the slot at position `grp_size`-1, only when the selected bitmap bit is 1, and the run has exactly `bub_len` slots; with `bub_len` equal to 0 no bubble slot appears.
- R4: In a bubble slot `slot_vld` is 0 and `slot_ch` keeps the value it had before that slot.
- R5: Each completed group cycle moves an inner pointer by one. While the inner pointer is below `len_inner`-1 the selected bit is `map_inner` bit [inner pointer] (bit 0 first); at `len_inner`-1 it is `map_outer` bit [outer pointer], after which the inner pointer returns to 0 and the outer pointer moves by one, returning to 0 after `len_outer`-1.
- R6: `frame_stb` returns the group position, both bitmap pointers and any pending bubbles to zero; a slot strobe in the same cycle is dropped and the outputs keep their values.
- R7: A write with `tbl_we` stores `tbl_data` at entry `tbl_addr`, and later slots at that position carry the new channel number.
- R8: In a cycle without a taken slot strobe, `slot_vld` and `slot_ch` keep their values.
- R9: With `SAMPLE_BYTES` set to 4 the schedule takes one step on every fourth slot strobe; `frame_stb` clears this byte count so the next step comes four strobes later.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_stb | input | 1 | Slot (or byte, in position mode) strobe |
| frame_stb | input | 1 | Frame boundary, restarts the schedule |
| grp_size | input | GRP_W | Number of positions in one round-robin cycle (1..NUM_CH) |
| map_inner | input | BMP_W | Inner bubble pattern, bit 0 used first |
| map_outer | input | BMP_W | Outer bubble pattern, bit 0 used first |
| len_inner | input | LEN_W | Inner pattern length (1..BMP_W) |
| len_outer | input | LEN_W | Outer pattern length (1..BMP_W) |
| bub_len | input | BUB_W | Bubble slots per insertion point |
| tbl_we | input | 1 | Lookup table write enable |
| tbl_addr | input | POS_W | Lookup table write address |
| tbl_data | input | CH_W | Channel number written |
| slot_vld | output | 1 | 1 for a channel slot, 0 for a bubble |
| slot_ch | output | CH_W | Channel number of the current slot |

## Verification
The checker takes for granted that `grp_size` lies between 1 and the table depth and that both pattern lengths lie between 1 and the bitmap width; it also assumes the configuration inputs change only right after a frame boundary. The stimulus rewrites the configuration only while it pulses `frame_stb` and keeps every value in range. A bench model follows the pointer rules above, so bubble runs, outer-pattern selection and frame restarts mid-cycle are all compared slot for slot.

// File: rtl/bss_pkg.sv
package bss_pkg;
   // Next value of a pointer that returns to zero after lim-1.
   function automatic logic [7:0] wrap_next(input logic [7:0] cur, input logic [7:0] lim);
      return (cur == lim - 8'd1) ? 8'd0 : cur + 8'd1;
   endfunction

   function automatic logic is_last(input logic [7:0] cur, input logic [7:0] lim);
      return cur == lim - 8'd1;
   endfunction
endpackage

// File: rtl/bss_chan_lut.sv
module bss_chan_lut #(
   parameter int DEPTH = 128,
   parameter int CH_W  = 7,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [CH_W-1:0] wr_data,
   input  logic [AW-1:0]   rd_addr,
   output logic [CH_W-1:0] rd_data
);
   logic [CH_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/bss_cadence.sv
module bss_cadence #(
   parameter int SAMPLE_BYTES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic stb,
   output logic adv
);
   generate
      if (SAMPLE_BYTES == 1) begin : g_msg
         assign adv = stb;
      end else begin : g_pos
         localparam int CW = $clog2(SAMPLE_BYTES);
         localparam logic [CW-1:0] LAST = CW'(SAMPLE_BYTES - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || clr) cnt <= '0;
            else if (stb)      cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
         end
         assign adv = stb && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/bss_bitmap_seq.sv
module bss_bitmap_seq
   import bss_pkg::*;
#(
   parameter int BMP_W = 32,
   localparam int PTR_W = $clog2(BMP_W),
   localparam int LEN_W = $clog2(BMP_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [BMP_W-1:0] map_inner,
   input  logic [BMP_W-1:0] map_outer,
   input  logic [LEN_W-1:0] len_inner,
   input  logic [LEN_W-1:0] len_outer,
   output logic             bub_bit
);
   logic [PTR_W-1:0] p_in, p_out;
   logic             at_end;

   assign at_end  = is_last(8'(p_in), 8'(len_inner));
   assign bub_bit = at_end ? map_outer[p_out] : map_inner[p_in];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         p_in  <= '0;
         p_out <= '0;
      end else if (step) begin
         p_in <= PTR_W'(wrap_next(8'(p_in), 8'(len_inner)));
         if (at_end) p_out <= PTR_W'(wrap_next(8'(p_out), 8'(len_outer)));
      end
   end
endmodule

// File: rtl/bmap_slot_sched.sv
module bmap_slot_sched #(
   parameter int NUM_CH       = 128,
   parameter int CH_W         = 7,
   parameter int BMP_W        = 32,
   parameter int BUB_W        = 4,
   parameter int SAMPLE_BYTES = 1,
   localparam int POS_W = $clog2(NUM_CH),
   localparam int GRP_W = $clog2(NUM_CH + 1),
   localparam int LEN_W = $clog2(BMP_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_stb,
   input  logic             frame_stb,
   input  logic [GRP_W-1:0] grp_size,
   input  logic [BMP_W-1:0] map_inner,
   input  logic [BMP_W-1:0] map_outer,
   input  logic [LEN_W-1:0] len_inner,
   input  logic [LEN_W-1:0] len_outer,
   input  logic [BUB_W-1:0] bub_len,
   input  logic             tbl_we,
   input  logic [POS_W-1:0] tbl_addr,
   input  logic [CH_W-1:0]  tbl_data,
   output logic             slot_vld,
   output logic [CH_W-1:0]  slot_ch
);
   if (NUM_CH < 2 || NUM_CH > 128) begin : g_bad_ch
      $error("NUM_CH must be within 2..128");
   end
   if ((1 << CH_W) < NUM_CH) begin : g_bad_chw
      $error("CH_W too narrow for NUM_CH");
   end
   if (BMP_W < 2 || BMP_W > 128) begin : g_bad_bmp
      $error("BMP_W must be within 2..128");
   end
   if (SAMPLE_BYTES != 1 && SAMPLE_BYTES != 2 && SAMPLE_BYTES != 4) begin : g_bad_sb
      $error("SAMPLE_BYTES must be 1, 2 or 4");
   end

   logic             adv, adv_ok, in_bub, grp_end, step, bub_bit;
   logic [POS_W-1:0] pos;
   logic [BUB_W-1:0] bub_cnt;
   logic [CH_W-1:0]  lut_ch;

   bss_cadence #(.SAMPLE_BYTES(SAMPLE_BYTES)) u_cad (
      .clk(clk), .rst_n(rst_n), .clr(frame_stb), .stb(slot_stb), .adv(adv)
   );

   assign adv_ok  = adv && !frame_stb;
   assign in_bub  = (bub_cnt != '0);
   assign grp_end = (GRP_W'(pos) == grp_size - GRP_W'(1));
   assign step    = adv_ok && !in_bub && grp_end;

   bss_bitmap_seq #(.BMP_W(BMP_W)) u_bmp (
      .clk(clk), .rst_n(rst_n), .clr(frame_stb), .step(step),
      .map_inner(map_inner), .map_outer(map_outer),
      .len_inner(len_inner), .len_outer(len_outer), .bub_bit(bub_bit)
   );

   bss_chan_lut #(.DEPTH(NUM_CH), .CH_W(CH_W)) u_lut (
      .clk(clk), .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_data(tbl_data),
      .rd_addr(pos), .rd_data(lut_ch)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos      <= '0;
         bub_cnt  <= '0;
         slot_vld <= 1'b0;
         slot_ch  <= '0;
      end else if (frame_stb) begin
         pos     <= '0;
         bub_cnt <= '0;
      end else if (adv_ok) begin
         if (in_bub) begin
            slot_vld <= 1'b0;
            bub_cnt  <= bub_cnt - BUB_W'(1);
         end else begin
            slot_vld <= 1'b1;
            slot_ch  <= lut_ch;
            if (grp_end) begin
               pos <= '0;
               if (bub_bit) bub_cnt <= bub_len;
            end else begin
               pos <= pos + POS_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/bss_checker.sv
module bss_checker #(
   parameter int POS_W = 7,
   parameter int CH_W  = 7,
   parameter int BUB_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_stb,
   input logic             adv_ok,
   input logic             in_bub,
   input logic             grp_end,
   input logic [POS_W-1:0] pos,
   input logic [BUB_W-1:0] bub_cnt,
   input logic             slot_vld,
   input logic [CH_W-1:0]  slot_ch
);
   // R4
   bubble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_ok && in_bub |=> !slot_vld && $stable(slot_ch));

   // R2
   data_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_ok && !in_bub |=> slot_vld);

   // R3
   mid_cycle_no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_ok && !in_bub && !grp_end |=> bub_cnt == '0);

   // R6
   frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |=> pos == '0 && bub_cnt == '0);

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_ok |=> $stable(slot_vld) && $stable(slot_ch));
endmodule

bind bmap_slot_sched bss_checker #(.POS_W(POS_W), .CH_W(CH_W), .BUB_W(BUB_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .adv_ok(adv_ok),
   .in_bub(in_bub), .grp_end(grp_end), .pos(pos), .bub_cnt(bub_cnt),
   .slot_vld(slot_vld), .slot_ch(slot_ch)
);

// File: tb/test_bmap_slot_sched.sv
`timescale 1ns/1ps
module test_bmap_slot_sched;
   localparam int NUM_CH = 128, CH_W = 7, BMP_W = 32, BUB_W = 4;
   localparam int POS_W = 7, GRP_W = 8, LEN_W = 6;

   logic clk = 1'b0, rst_n = 1'b0, slot_stb = 1'b0, pstb = 1'b0, frame_stb = 1'b0;
   logic [GRP_W-1:0] grp_size = 8'd3;
   logic [BMP_W-1:0] map_inner = '0, map_outer = '0;
   logic [LEN_W-1:0] len_inner = 6'd1, len_outer = 6'd1;
   logic [BUB_W-1:0] bub_len = '0;
   logic tbl_we = 1'b0;
   logic [POS_W-1:0] tbl_addr = '0;
   logic [CH_W-1:0] tbl_data = '0;
   logic slot_vld, pos_vld;
   logic [CH_W-1:0] slot_ch, pos_ch;

   always #2.5 clk = ~clk;

   bmap_slot_sched i_bmap_slot_sched (
      .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .frame_stb(frame_stb),
      .grp_size(grp_size), .map_inner(map_inner), .map_outer(map_outer),
      .len_inner(len_inner), .len_outer(len_outer), .bub_len(bub_len),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
      .slot_vld(slot_vld), .slot_ch(slot_ch));

   bmap_slot_sched #(.SAMPLE_BYTES(4)) i_bmap_slot_sched_pos (
      .clk(clk), .rst_n(rst_n), .slot_stb(pstb), .frame_stb(frame_stb),
      .grp_size(grp_size), .map_inner(map_inner), .map_outer(map_outer),
      .len_inner(len_inner), .len_outer(len_outer), .bub_len(bub_len),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
      .slot_vld(pos_vld), .slot_ch(pos_ch));

   int n_vec = 0, n_bad = 0;
   logic [CH_W-1:0] m_tbl [NUM_CH];
   int m_pos = 0, m_p1 = 0, m_p2 = 0, m_bub = 0;
   logic [CH_W-1:0] m_last = '0;
   logic [CH_W:0] exp_q[$];
   string req_q[$];

   task automatic check(input logic [CH_W:0] act, input logic [CH_W:0] exp, input string r);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: vld/ch actual %0b/%0d expected %0b/%0d",
                  r, act[CH_W], act[CH_W-1:0], exp[CH_W], exp[CH_W-1:0]);
      end
   endtask

   // Scoreboard monitor: compares one item per taken slot strobe.
   always @(posedge clk) begin
      if (slot_stb && !frame_stb && rst_n) begin
         #1;
         if (exp_q.size() == 0) begin
            n_vec++; n_bad++;
            $display("FAIL R2: unexpected slot, actual %0d expected none", slot_ch);
         end else begin
            check({slot_vld, slot_ch}, exp_q.pop_front(), req_q.pop_front());
         end
      end
   end

   task automatic model_frame();
      m_pos = 0; m_p1 = 0; m_p2 = 0; m_bub = 0;
   endtask

   // Driver: computes the expected slot from the requirements and applies the strobe.
   task automatic do_slot(input string r);
      logic bit_sel;
      if (m_bub != 0) begin
         m_bub--;
         exp_q.push_back({1'b0, m_last});
      end else begin
         m_last = m_tbl[m_pos];
         exp_q.push_back({1'b1, m_last});
         if (m_pos == int'(grp_size) - 1) begin
            m_pos = 0;
            bit_sel = (m_p1 == int'(len_inner) - 1) ? map_outer[m_p2] : map_inner[m_p1];
            if (bit_sel) m_bub = int'(bub_len);
            if (m_p1 == int'(len_inner) - 1) begin
               m_p1 = 0;
               m_p2 = (m_p2 == int'(len_outer) - 1) ? 0 : m_p2 + 1;
            end else m_p1++;
         end else m_pos++;
      end
      req_q.push_back(r);
      slot_stb = 1'b1;
      @(negedge clk);
      slot_stb = 1'b0;
   endtask

   task automatic frame();
      model_frame();
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
   endtask

   task automatic wr_tbl(input int a, input int d);
      tbl_we = 1'b1; tbl_addr = POS_W'(a); tbl_data = CH_W'(d);
      m_tbl[a] = CH_W'(d);
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic pulse_pos(input int n);
      for (int i = 0; i < n; i++) begin
         pstb = 1'b1; @(negedge clk); pstb = 1'b0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [CH_W:0] held;
      repeat (3) @(negedge clk);
      // R1: reset state
      check({slot_vld, slot_ch}, {1'b0, 7'd0}, "R1");
      check({pos_vld, pos_ch}, {1'b0, 7'd0}, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      // R7: fill the table
      for (int i = 0; i < NUM_CH; i++) wr_tbl(i, (i * 5 + 3) % 128);
      frame();

      // R2: plain round-robin, group of 3, bubbles enabled but no bit set
      grp_size = 8'd3; bub_len = 4'd2; len_inner = 6'd4; len_outer = 6'd2;
      frame();
      for (int i = 0; i < 9; i++) do_slot("R2");

      // R3 R4 R5: inner bit 0, outer bit 1 set
      map_inner = 32'h1; len_inner = 6'd3; map_outer = 32'h2; len_outer = 6'd2;
      frame();
      for (int i = 0; i < 40; i++) do_slot("R5");

      // R3: zero bubble length with every bit set
      map_inner = '1; map_outer = '1; bub_len = 4'd0; grp_size = 8'd4;
      frame();
      for (int i = 0; i < 12; i++) do_slot("R3");

      // R4: long bubble runs, group of 1
      grp_size = 8'd1; bub_len = 4'd3; len_inner = 6'd2; map_inner = 32'h0;
      map_outer = 32'h1; len_outer = 6'd1;
      frame();
      for (int i = 0; i < 16; i++) do_slot("R4");

      // R6: frame in mid-cycle restarts at position 0
      grp_size = 8'd5; map_inner = 32'h2; len_inner = 6'd3; map_outer = '0; bub_len = 4'd1;
      frame();
      for (int i = 0; i < 7; i++) do_slot("R6");
      frame();
      for (int i = 0; i < 6; i++) do_slot("R6");
      // R6: frame and slot strobe together, slot dropped
      @(negedge clk);
      held = {slot_vld, slot_ch};
      model_frame();
      frame_stb = 1'b1; slot_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0; slot_stb = 1'b0;
      check({slot_vld, slot_ch}, held, "R6");
      for (int i = 0; i < 6; i++) do_slot("R6");

      // R7: rewrite entry 1 and see it in later slots
      wr_tbl(1, 99);
      frame();
      for (int i = 0; i < 6; i++) do_slot("R7");

      // R8: idle cycles hold outputs
      held = {slot_vld, slot_ch};
      repeat (5) @(negedge clk);
      check({slot_vld, slot_ch}, held, "R8");

      // R9: position mode, one step per four strobes
      grp_size = 8'd2; map_inner = '0; map_outer = '0; bub_len = 4'd0;
      frame();
      pulse_pos(3);
      check({pos_vld, pos_ch}, {1'b0, 7'd0}, "R9");
      pulse_pos(1);
      check({pos_vld, pos_ch}, {1'b1, m_tbl[0]}, "R9");
      pulse_pos(4);
      check({pos_vld, pos_ch}, {1'b1, m_tbl[1]}, "R9");
      pulse_pos(2);
      frame();
      pulse_pos(3);
      check({pos_vld, pos_ch}, {1'b1, m_tbl[1]}, "R9");
      pulse_pos(1);
      check({pos_vld, pos_ch}, {1'b1, m_tbl[0]}, "R9");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_vec++; n_bad++;
         $display("FAIL R2: actual %0d pending items expected 0", exp_q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule